// File: doc/BRIEF.md
# Two-Set Square-Wave Carrier Generator

This block turns a prescaled clock enable into a square-wave carrier. Each carrier period opens with a high phase and closes with a low phase. Each phase lasts a programmed number of enable ticks, so the period and the duty cycle are both set by two 8-bit counts.

The block holds two count pairs, a primary pair and a secondary pair. In time mode and in baseband mode the primary pair always drives the carrier. In frequency-shift mode, a modulator that sits downstream can ask for a set swap once each of its cycles ends. The swap then takes effect at the next carrier period boundary, which lets the carrier alternate between two frequencies.

The generator marks the final tick of every low phase with a one-cycle pulse. The modulator counts these pulses. New count values are taken in only while the generator is idle or at a period boundary, so changing them mid-phase never produces a short or glitched phase.

Top module: `fsk_carrier_gen`

## Requirements
- R1: When running with a high count H and a low count L, the carrier is high for exactly H ticks and then low for exactly L ticks. The period is H+L ticks. While the generator is active, the carrier is high in the cycle it first becomes active.
- R2: Cycles without `tick` advance nothing. Both the carrier level and the phase position stay as they are.
- R3: The generator runs when `mode` is 8'h01 (time), 8'h05 (frequency-shift) or 8'h09 (baseband) and `enable` is 1. Mode 8'h00 (direct control) and every other code leave the generator disabled.
- R4: While the generator is disabled, `carrier` and `period_end` are 0. The generator also returns to the start of the high phase with the primary set selected and any pending swap cleared. It reloads the primary counts every cycle.
- R5: `period_end` is 1 for exactly the cycle whose tick completes a low phase, and is 0 at every other time.
- R6: In mode 8'h05, a `swap_req` pulse is held pending until the next period boundary, where the active set toggles once. Any number of requests before that boundary still produce a single toggle. A request in the same cycle as the boundary takes effect at that boundary.
- R7: The secondary pair is used only in mode 8'h05. In any other mode `swap_req` is ignored. A period boundary outside mode 8'h05 reloads the primary pair and selects it.
- R8: Count inputs are sampled only at a period boundary or while the generator is idle. A change during a period has no effect until the next boundary.
- R9: A count of 0 behaves as 256 ticks.
- R10: After reset, `carrier` and `period_end` are 0, and the generator waits at the start of the high phase on the primary set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Prescaled clock enable; one count step per asserted cycle |
| enable | input | 1 | Generator enable |
| mode | input | MW | Operating mode code |
| pri_high | input | CW | Primary high-phase count |
| pri_low | input | CW | Primary low-phase count |
| sec_high | input | CW | Secondary high-phase count |
| sec_low | input | CW | Secondary low-phase count |
| swap_req | input | 1 | Set-swap request from the modulator (frequency-shift mode) |
| carrier | output | 1 | Carrier level |
| period_end | output | 1 | Pulse on the final tick of each carrier period |

## Verification
The delicate collision is a set-swap request that arrives in the same cycle as the tick that ends a period. That request has to be folded into the boundary decision, not deferred by a full period. The bench provokes this by running frequency-shift mode with one-tick phases and a random stream of swap requests, so coincidences happen many times. A behavioural reference model predicts each output on every clock, so a swap applied one period late shows up as a wrong carrier width in the following period.

// File: rtl/fsk_carrier_gen.sv
module fsk_carrier_gen #(
  parameter int CW = 8,
  parameter int MW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          enable,
  input  logic [MW-1:0] mode,
  input  logic [CW-1:0] pri_high,
  input  logic [CW-1:0] pri_low,
  input  logic [CW-1:0] sec_high,
  input  logic [CW-1:0] sec_low,
  input  logic          swap_req,
  output logic          carrier,
  output logic          period_end
);
  localparam int LW = CW + 1;
  localparam logic [MW-1:0] MODE_TIME = MW'(1);
  localparam logic [MW-1:0] MODE_FSK  = MW'(5);
  localparam logic [MW-1:0] MODE_BASE = MW'(9);
  localparam logic [LW-1:0] FULL      = LW'(1) << CW;

  logic          run, fsk;
  logic          phase_q, sel_q, pend_q;
  logic [CW-1:0] cnt_q, hi_q, lo_q, cur;
  logic [LW-1:0] lim, nxt;
  logic          last, pend_n, sel_n;

  assign run    = enable && (mode == MODE_TIME || mode == MODE_FSK || mode == MODE_BASE);
  assign fsk    = (mode == MODE_FSK);
  assign cur    = phase_q ? lo_q : hi_q;
  assign lim    = (cur == '0) ? FULL : {1'b0, cur};
  assign nxt    = {1'b0, cnt_q} + LW'(1);
  assign last   = (nxt == lim);
  assign pend_n = pend_q | (fsk & swap_req);
  assign sel_n  = fsk & (sel_q ^ pend_n);

  assign carrier    = run && !phase_q;
  assign period_end = run && tick && phase_q && last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= 1'b0;
      cnt_q   <= '0;
      sel_q   <= 1'b0;
      pend_q  <= 1'b0;
      hi_q    <= '0;
      lo_q    <= '0;
    end else if (!run) begin
      phase_q <= 1'b0;
      cnt_q   <= '0;
      sel_q   <= 1'b0;
      pend_q  <= 1'b0;
      hi_q    <= pri_high;
      lo_q    <= pri_low;
    end else begin
      pend_q <= pend_n;
      if (tick) begin
        if (!last) begin
          cnt_q <= nxt[CW-1:0];
        end else if (!phase_q) begin
          phase_q <= 1'b1;
          cnt_q   <= '0;
        end else begin
          phase_q <= 1'b0;
          cnt_q   <= '0;
          sel_q   <= sel_n;
          pend_q  <= 1'b0;
          hi_q    <= sel_n ? sec_high : pri_high;
          lo_q    <= sel_n ? sec_low  : pri_low;
        end
      end
    end
  end
endmodule

// File: rtl/fsk_carrier_gen_chk.sv
module fsk_carrier_gen_chk #(
  parameter int CW = 8,
  parameter int MW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic          enable,
  input logic [MW-1:0] mode,
  input logic          carrier,
  input logic          period_end
);
  logic act;
  assign act = enable && (mode == MW'(1) || mode == MW'(5) || mode == MW'(9));

  p_idle_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !act |-> (!carrier && !period_end));

  p_end_on_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
    period_end |-> (tick && !carrier));

  p_end_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    period_end |=> !period_end);

  p_hold_no_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (act && !tick) |=> (!act || $stable(carrier)));

  p_rise_after_end_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (act && $past(act) && $rose(carrier)) |-> $past(period_end));
endmodule

bind fsk_carrier_gen fsk_carrier_gen_chk #(.CW(CW), .MW(MW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .enable(enable), .mode(mode),
  .carrier(carrier), .period_end(period_end)
);

// File: tb/tb_fsk_carrier_gen.sv
module tb_fsk_carrier_gen;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic       clk, rst_n, tick, enable, swap_req;
  logic [7:0] mode, pri_high, pri_low, sec_high, sec_low;
  logic       carrier, period_end;

  fsk_carrier_gen dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .enable(enable), .mode(mode),
    .pri_high(pri_high), .pri_low(pri_low), .sec_high(sec_high), .sec_low(sec_low),
    .swap_req(swap_req), .carrier(carrier), .period_end(period_end)
  );

  int vectors = 0, miscompares = 0, collisions = 0;
  int tick_rate = 0, swap_rate = 0;
  string cur_req = "R10";

  int m_ph, m_cnt, m_hi, m_lo, m_sel, m_pend, m_lim, m_np, m_ns;
  bit m_act, m_fsk, e_car, e_end;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int eff(input logic [7:0] v);
    return (v == 8'd0) ? 256 : int'(v);
  endfunction

  task automatic check(input string what, input logic got, input bit exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s %s got %b expected %b at %0t", cur_req, what, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_cnt = 0; m_hi = 256; m_lo = 256; m_sel = 0; m_pend = 0;
    end else begin
      m_act = enable && (mode == 8'h01 || mode == 8'h05 || mode == 8'h09);
      m_fsk = (mode == 8'h05);
      m_lim = (m_ph == 0) ? m_hi : m_lo;
      e_car = m_act && (m_ph == 0);
      e_end = m_act && tick && (m_ph == 1) && (m_cnt + 1 == m_lim);
      check("carrier", carrier, e_car);
      check("period_end", period_end, e_end);
      if (e_end && swap_req && m_fsk) collisions++;
      if (!m_act) begin
        m_ph = 0; m_cnt = 0; m_sel = 0; m_pend = 0;
        m_hi = eff(pri_high); m_lo = eff(pri_low);
      end else begin
        m_np = (m_pend != 0 || (m_fsk && swap_req)) ? 1 : 0;
        if (tick) begin
          if (m_cnt + 1 != m_lim) m_cnt++;
          else if (m_ph == 0) begin m_ph = 1; m_cnt = 0; end
          else begin
            m_ns = m_fsk ? (m_sel ^ m_np) : 0;
            m_sel = m_ns; m_np = 0; m_ph = 0; m_cnt = 0;
            m_hi = eff(m_sel != 0 ? sec_high : pri_high);
            m_lo = eff(m_sel != 0 ? sec_low : pri_low);
          end
        end
        m_pend = m_np;
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) begin
      @(posedge clk); #1;
      tick     = (tick_rate == 0) ? 1'b1 : ($urandom_range(tick_rate - 1) == 0);
      swap_req = (swap_rate == 0) ? 1'b0 : ($urandom_range(swap_rate - 1) == 0);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired got running expected finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; tick = 1'b0; enable = 1'b0; swap_req = 1'b0; mode = 8'h00;
    pri_high = 8'd3; pri_low = 8'd2; sec_high = 8'd5; sec_low = 8'd4;
    cyc(3);
    rst_n = 1'b1;
    cur_req = "R10"; cyc(4);
    cur_req = "R1"; mode = 8'h01; enable = 1'b1; cyc(40);
    cur_req = "R2"; tick_rate = 3; cyc(60);
    cur_req = "R3"; tick_rate = 0;
    mode = 8'h00; cyc(10); mode = 8'h02; cyc(10); mode = 8'h09; cyc(20);
    mode = 8'h05; cyc(20); mode = 8'h0D; cyc(10); mode = 8'h01; cyc(10);
    cur_req = "R4"; enable = 1'b0; pri_high = 8'd4; pri_low = 8'd1; cyc(5);
    enable = 1'b1; cyc(20); mode = 8'h00; cyc(3); mode = 8'h01; cyc(15);
    cur_req = "R5"; pri_high = 8'd1; pri_low = 8'd1; tick_rate = 2; cyc(40);
    cur_req = "R6"; tick_rate = 0; mode = 8'h05;
    pri_high = 8'd2; pri_low = 8'd1; sec_high = 8'd1; sec_low = 8'd3;
    swap_rate = 4; cyc(300);
    pri_high = 8'd1; pri_low = 8'd1; sec_high = 8'd2; sec_low = 8'd2;
    swap_rate = 3; cyc(150);
    cur_req = "R7"; mode = 8'h01; swap_rate = 2; cyc(60);
    swap_rate = 0; mode = 8'h05; cyc(4); swap_rate = 1; cyc(1); swap_rate = 0; cyc(12);
    mode = 8'h01; cyc(20);
    cur_req = "R8"; pri_high = 8'd6; pri_low = 8'd5; cyc(3);
    pri_high = 8'd2; pri_low = 8'd2; cyc(3);
    pri_high = 8'd7; pri_low = 8'd3; cyc(30);
    cur_req = "R9"; pri_high = 8'd0; pri_low = 8'd1; enable = 1'b0; cyc(2);
    enable = 1'b1; cyc(600);
    pri_high = 8'd2; pri_low = 8'd0; cyc(600);
    if (collisions == 0) begin
      vectors++; miscompares++;
      $display("FAIL R6 swap/boundary coincidences got 0 expected >0");
    end
    finish_run();
  end
endmodule